// File: doc/BRIEF.md
# Synchronous Microprocessor Bus Register Slave

This block terminates a synchronous, strobe-qualified processor bus and gives it access to a set of internal register banks. On each clock it looks at an active-low chip select and an active-low one-clock address strobe. When both are low and no earlier access is still open, it latches the bank, the register index and the direction. It then counts a latency that depends on the bank, performs the register access, and answers with an active-low transfer acknowledge.

Each bank has its own acknowledge latency. One bank is also written and read by an internal overhead-access port. That bank answers the bus much more slowly, and the internal port has priority over the bus at the moment of access. The acknowledge pad is modelled as a sequencer drive enable, a drive value and a final output enable qualified by chip select. The enable lets the testbench rebuild the tri-state behaviour.

Top module: `mpu_bus_slave`

## Requirements
- R1: After reset the acknowledge is not driven (`ack_drv_o`=0, `ack_oe_o`=0), its value rests high (`ack_val_o`=1), and `rdata_o` is 0. All registers reset to 0.
- R2: An access is accepted at a rising edge where `as_ni`=0, `cs_ni`=0 and the block is idle. The bank is `addr_i[20:19]` and the register index is `addr_i[2:0]`. For banks 0, 1 and 2 the acknowledge goes low in the clock period that starts at the 4th rising edge after the accepting edge.
- R3: The acknowledge is driven low (`ack_drv_o`=1, `ack_val_o`=0) for exactly one clock, then driven high for one clock, then the drive is released. The value is high whenever it is not driven.
- R4: `ack_oe_o` is 1 only while the acknowledge is driven and `cs_ni` is low. While `cs_ni` is high it is always 0.
- R5: `rw_i`=0 at the accepting edge marks a write; 1 marks a read. Write data is taken from `wdata_i` at the rising edge that follows the accepting edge. Data present during the strobe clock is not used.
- R6: For a read, `rdata_o` holds the addressed register value while the acknowledge is low.
- R7: Bank 3 is the shared bank. Without internal-port activity its acknowledge goes low 32 rising edges after the accepting edge.
- R8: The internal port (`ovh_req_i`, `ovh_we_i`, `ovh_idx_i`, `ovh_wdata_i`) accesses bank 3 on every edge where it requests. At the bus access point the internal port wins, and the bus access is delayed one clock per requesting edge without being dropped. `ovh_rdata_o` shows the bank 3 register chosen by `ovh_idx_i` and is updated without delay.
- R9: A strobe that arrives before the open access has finished its acknowledge sequence is ignored. It causes no register change and no extra acknowledge.
- R10: A strobe sampled while `cs_ni` is high is ignored. It causes no register change and no acknowledge.
- R11: Every accepted access is acknowledged within 64 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 21 | Bus address, stable for the whole cycle |
| cs_ni | input | 1 | Chip select, active low |
| as_ni | input | 1 | Address strobe, active low, one clock wide |
| rw_i | input | 1 | 1 = read, 0 = write |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |
| ack_drv_o | output | 1 | Acknowledge drive enable from the sequencer |
| ack_val_o | output | 1 | Acknowledge drive value (low = acknowledge) |
| ack_oe_o | output | 1 | Acknowledge pad output enable, qualified by chip select |
| ovh_req_i | input | 1 | Internal port request to the shared bank |
| ovh_we_i | input | 1 | Internal port write enable |
| ovh_idx_i | input | 3 | Internal port register index |
| ovh_wdata_i | input | 16 | Internal port write data |
| ovh_rdata_o | output | 16 | Internal port read data |

## Verification
Writes followed by read-back across the three plain banks, each with its own index and data, show whether the bank and index decode and the 4-clock latency are correct. During each strobe clock the data bus carries a corrupted value, which exposes a design that samples write data one clock early. The shared bank is tried both quiet and with an internal write held across the bus access point. The second case separates a correct stall-and-retry, which gives 35 clocks and returns the internal value, from an access that is dropped or that ignores the internal port. Strobes sent during a busy cycle, strobes sent with chip select high, and chip select dropped in the middle of a cycle show whether accept gating and pad qualification are correct.

// File: rtl/mpu_slave_pkg.sv
package mpu_slave_pkg;
  localparam int ADDR_W = 21;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACK_LO,
    ST_ACK_HI
  } seq_state_e;
endpackage

// File: rtl/mpu_cycle_decode.sv
module mpu_cycle_decode
  import mpu_slave_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int IDX_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              as_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              idle_i,
  output logic              start_o,
  output logic [BANK_W-1:0] req_bank_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              wr_o,
  output logic [DATA_W-1:0] wdata_o
);
  logic data_phase_q;
  logic unused_addr;

  assign unused_addr = ^addr_i[ADDR_W-BANK_W-1:IDX_W];
  assign start_o     = !as_ni && !cs_ni && idle_i;
  assign req_bank_o  = addr_i[ADDR_W-1 -: BANK_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_o       <= '0;
      idx_o        <= '0;
      wr_o         <= 1'b0;
      wdata_o      <= '0;
      data_phase_q <= 1'b0;
    end else begin
      data_phase_q <= start_o;
      if (start_o) begin
        bank_o <= req_bank_o;
        idx_o  <= addr_i[IDX_W-1:0];
        wr_o   <= !rw_i;
      end
      // data phase is the clock after the strobe
      if (data_phase_q && wr_o) wdata_o <= wdata_i;
    end
  end
endmodule

// File: rtl/mpu_ack_seq.sv
module mpu_ack_seq
  import mpu_slave_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int SHARED_BANK = 3,
  parameter int NORM_LAT    = 4,
  parameter int SHARED_LAT  = 32,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int MAX_LAT    = (SHARED_LAT > NORM_LAT) ? SHARED_LAT : NORM_LAT,
  localparam int CNT_W      = $clog2(MAX_LAT + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ovh_busy_i,
  output logic              idle_o,
  output logic              commit_o,
  output logic              ack_drv_o,
  output logic              ack_val_o
);
  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lat_tbl [NUM_BANKS];
  logic             blocked;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_lat
    if (b == SHARED_BANK) begin : g_shr
      assign lat_tbl[b] = CNT_W'(SHARED_LAT - 1);
    end else begin : g_norm
      assign lat_tbl[b] = CNT_W'(NORM_LAT - 1);
    end
  end

  assign blocked   = (bank_i == BANK_W'(SHARED_BANK)) && ovh_busy_i;
  assign idle_o    = (state_q == ST_IDLE);
  assign commit_o  = (state_q == ST_WAIT) && (cnt_q == '0) && !blocked;
  assign ack_drv_o = (state_q == ST_ACK_LO) || (state_q == ST_ACK_HI);
  assign ack_val_o = (state_q != ST_ACK_LO);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          cnt_q   <= lat_tbl[req_bank_i];
        end
        ST_WAIT: begin
          if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
          else if (!blocked) state_q <= ST_ACK_LO;
        end
        ST_ACK_LO: state_q <= ST_ACK_HI;
        ST_ACK_HI: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpu_reg_banks.sv
module mpu_reg_banks
  import mpu_slave_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int SHARED_BANK   = 3,
  localparam int BANK_W       = $clog2(NUM_BANKS),
  localparam int IDX_W        = $clog2(REGS_PER_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [BANK_W-1:0] bus_bank_i,
  input  logic [IDX_W-1:0]  bus_idx_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              ovh_we_i,
  input  logic [IDX_W-1:0]  ovh_idx_i,
  input  logic [DATA_W-1:0] ovh_wdata_i,
  output logic [DATA_W-1:0] ovh_rdata_o
);
  logic [DATA_W-1:0] regs [NUM_BANKS][REGS_PER_BANK];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < REGS_PER_BANK; r++) begin : g_reg
      logic bus_hit, ovh_hit;
      assign bus_hit = bus_we_i && (bus_bank_i == BANK_W'(b)) && (bus_idx_i == IDX_W'(r));
      if (b == SHARED_BANK) begin : g_shr
        assign ovh_hit = ovh_we_i && (ovh_idx_i == IDX_W'(r));
      end else begin : g_prv
        assign ovh_hit = 1'b0;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      regs[b][r] <= '0;
        else if (ovh_hit) regs[b][r] <= ovh_wdata_i;
        else if (bus_hit) regs[b][r] <= bus_wdata_i;
      end
    end
  end

  assign bus_rdata_o = regs[bus_bank_i][bus_idx_i];
  assign ovh_rdata_o = regs[SHARED_BANK][ovh_idx_i];
endmodule

// File: rtl/mpu_bus_slave.sv
module mpu_bus_slave
  import mpu_slave_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int REGS_PER_BANK = 8,
  parameter int SHARED_BANK   = 3,
  parameter int NORM_LAT      = 4,
  parameter int SHARED_LAT    = 32,
  localparam int BANK_W       = $clog2(NUM_BANKS),
  localparam int IDX_W        = $clog2(REGS_PER_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_ni,
  input  logic              as_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ack_drv_o,
  output logic              ack_val_o,
  output logic              ack_oe_o,
  input  logic              ovh_req_i,
  input  logic              ovh_we_i,
  input  logic [IDX_W-1:0]  ovh_idx_i,
  input  logic [DATA_W-1:0] ovh_wdata_i,
  output logic [DATA_W-1:0] ovh_rdata_o
);
  logic              start, idle, commit, cyc_wr;
  logic [BANK_W-1:0] req_bank, cyc_bank;
  logic [IDX_W-1:0]  cyc_idx;
  logic [DATA_W-1:0] cyc_wdata, bank_rdata;

  mpu_cycle_decode #(.BANK_W(BANK_W), .IDX_W(IDX_W)) u_dec (
    .clk_i, .rst_ni, .addr_i, .cs_ni, .as_ni, .rw_i, .wdata_i,
    .idle_i     (idle),
    .start_o    (start),
    .req_bank_o (req_bank),
    .bank_o     (cyc_bank),
    .idx_o      (cyc_idx),
    .wr_o       (cyc_wr),
    .wdata_o    (cyc_wdata)
  );

  mpu_ack_seq #(
    .NUM_BANKS(NUM_BANKS), .SHARED_BANK(SHARED_BANK),
    .NORM_LAT(NORM_LAT), .SHARED_LAT(SHARED_LAT)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .req_bank_i (req_bank),
    .bank_i     (cyc_bank),
    .ovh_busy_i (ovh_req_i),
    .idle_o     (idle),
    .commit_o   (commit),
    .ack_drv_o, .ack_val_o
  );

  mpu_reg_banks #(
    .NUM_BANKS(NUM_BANKS), .REGS_PER_BANK(REGS_PER_BANK), .SHARED_BANK(SHARED_BANK)
  ) u_regs (
    .clk_i, .rst_ni,
    .bus_we_i    (commit && cyc_wr),
    .bus_bank_i  (cyc_bank),
    .bus_idx_i   (cyc_idx),
    .bus_wdata_i (cyc_wdata),
    .bus_rdata_o (bank_rdata),
    .ovh_we_i    (ovh_req_i && ovh_we_i),
    .ovh_idx_i, .ovh_wdata_i, .ovh_rdata_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               rdata_o <= '0;
    else if (commit && !cyc_wr) rdata_o <= bank_rdata;
  end

  assign ack_oe_o = ack_drv_o && !cs_ni;
endmodule

// File: rtl/mpu_bus_slave_chk.sv
module mpu_bus_slave_chk #(
  parameter int BANK_W      = 2,
  parameter int SHARED_BANK = 3,
  parameter int NORM_LAT    = 4,
  parameter int SHARED_LAT  = 32
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [20:0] addr_i,
  input logic        cs_ni,
  input logic        as_ni,
  input logic        ack_drv_o,
  input logic        ack_val_o,
  input logic        ack_oe_o
);
  logic       pend_q, shr_q;
  logic [7:0] age_q;
  logic       acc;

  assign acc = !as_ni && !cs_ni && !pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      shr_q  <= 1'b0;
      age_q  <= '0;
    end else if (acc) begin
      pend_q <= 1'b1;
      shr_q  <= (addr_i[20 -: BANK_W] == BANK_W'(SHARED_BANK));
      age_q  <= '0;
    end else if (pend_q) begin
      if (ack_drv_o && ack_val_o) pend_q <= 1'b0;
      if (age_q != 8'hff) age_q <= age_q + 8'd1;
    end
  end

  assert_val_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_drv_o |-> ack_val_o);
  assert_lat_norm_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !shr_q && ack_drv_o && !ack_val_o) |-> (age_q == 8'(NORM_LAT)));
  assert_ack_one_clk_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_drv_o && !ack_val_o) |=> (ack_drv_o && ack_val_o));
  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_drv_o && ack_val_o) |=> !ack_drv_o);
  assert_oe_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |-> !ack_oe_o);
  assert_oe_drv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_oe_o |-> ack_drv_o);
  assert_lat_shr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && shr_q && ack_drv_o && !ack_val_o) |-> (age_q >= 8'(SHARED_LAT)));
  assert_no_spurious_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_drv_o |-> pend_q);
  assert_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (age_q < 8'd64));
endmodule

bind mpu_bus_slave mpu_bus_slave_chk #(
  .BANK_W(BANK_W), .SHARED_BANK(SHARED_BANK),
  .NORM_LAT(NORM_LAT), .SHARED_LAT(SHARED_LAT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .cs_ni(cs_ni), .as_ni(as_ni),
  .ack_drv_o(ack_drv_o), .ack_val_o(ack_val_o), .ack_oe_o(ack_oe_o)
);

// File: tb/mpu_bus_slave_tb.sv
module mpu_bus_slave_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [20:0] addr = '0;
  logic        cs_n = 1'b1, as_n = 1'b1, rw = 1'b1;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ack_drv, ack_val, ack_oe;
  logic        ovh_req = 1'b0, ovh_we = 1'b0;
  logic [2:0]  ovh_idx = '0;
  logic [15:0] ovh_wdata = '0, ovh_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [15:0] model [4][8];
  bit done = 0;

  always #10 clk = ~clk;

  mpu_bus_slave u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .cs_ni(cs_n), .as_ni(as_n),
    .rw_i(rw), .wdata_i(wdata), .rdata_o(rdata),
    .ack_drv_o(ack_drv), .ack_val_o(ack_val), .ack_oe_o(ack_oe),
    .ovh_req_i(ovh_req), .ovh_we_i(ovh_we), .ovh_idx_i(ovh_idx),
    .ovh_wdata_i(ovh_wdata), .ovh_rdata_o(ovh_rdata)
  );

  function automatic logic [20:0] mk_addr(int bank, int idx);
    return {bank[1:0], 16'h0, idx[2:0]};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_cycle(int bank, int idx, bit wr, logic [15:0] d);
    @(negedge clk);
    addr = mk_addr(bank, idx); cs_n = 0; as_n = 0; rw = !wr;
    wdata = d ^ 16'hdead;              // wrong data during strobe clock
    @(negedge clk);
    as_n = 1; wdata = d;
  endtask

  task automatic wait_ack(output int lat);
    lat = -1;
    for (int m = 1; m <= 80; m++) begin
      @(negedge clk);
      if (ack_drv && !ack_val) begin lat = m; break; end
    end
  endtask

  task automatic end_cycle();
    @(negedge clk);
    chk(ack_drv && ack_val, "R3 ack driven high after low", {ack_drv, ack_val}, 3);
    @(negedge clk);
    chk(!ack_drv, "R3 ack released", ack_drv, 0);
    cs_n = 1; rw = 1;
  endtask

  task automatic do_access(int bank, int idx, bit wr, logic [15:0] d, int exp_lat, string tag);
    int lat;
    start_cycle(bank, idx, wr, d);
    wait_ack(lat);
    chk(lat == exp_lat, tag, lat, exp_lat);
    chk(lat > 0 && lat < 64, "R11 acknowledged within 64 clocks", lat, exp_lat);
    chk(ack_oe == 1'b1, "R4 oe while cs low and ack driven", ack_oe, 1);
    if (wr) model[bank][idx] = d;
    else chk(rdata == model[bank][idx], "R6 read data", rdata, model[bank][idx]);
    end_cycle();
  endtask

  task automatic t_reset();
    for (int b = 0; b < 4; b++) for (int r = 0; r < 8; r++) model[b][r] = '0;
    repeat (3) @(negedge clk);
    chk(!ack_drv && !ack_oe && ack_val && rdata == 0, "R1 reset outputs",
        {ack_drv, ack_oe, ack_val}, 3'b001);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic t_normal();
    do_access(0, 1, 1, 16'ha5a5, 4, "R2 R5 bank0 write latency");
    do_access(1, 7, 1, 16'h1234, 4, "R2 R5 bank1 write latency");
    do_access(2, 0, 1, 16'hffff, 4, "R2 R5 bank2 write latency");
    do_access(0, 1, 0, 0, 4, "R2 bank0 read latency");
    do_access(1, 7, 0, 0, 4, "R2 bank1 read latency");
    do_access(2, 0, 0, 0, 4, "R2 bank2 read latency");
    do_access(1, 6, 0, 0, 4, "R2 unwritten read latency");
  endtask

  task automatic t_shared();
    do_access(3, 2, 1, 16'hbeef, 32, "R7 shared write latency");
    do_access(3, 2, 0, 0, 32, "R7 shared read latency");
    @(negedge clk);
    ovh_idx = 2;
    #1 chk(ovh_rdata == 16'hbeef, "R8 internal read of bus-written reg", ovh_rdata, 16'hbeef);
  endtask

  task automatic t_contend();
    int lat;
    start_cycle(3, 5, 0, 0);
    fork
      wait_ack(lat);
      begin
        repeat (31) @(negedge clk);
        ovh_req = 1; ovh_we = 1; ovh_idx = 5; ovh_wdata = 16'h7e57;
        repeat (3) @(negedge clk);
        ovh_req = 0; ovh_we = 0;
      end
    join
    model[3][5] = 16'h7e57;
    chk(lat == 35, "R8 bus access stalled by internal port", lat, 35);
    chk(rdata == 16'h7e57, "R8 bus read sees internal write", rdata, 16'h7e57);
    end_cycle();
  endtask

  task automatic t_busy();
    int lat;
    bit extra;
    start_cycle(0, 3, 1, 16'h1111);
    fork
      wait_ack(lat);
      begin
        repeat (2) @(negedge clk);
        addr = mk_addr(0, 4); rw = 0; as_n = 0; wdata = 16'h2222;
        @(negedge clk);
        as_n = 1;
      end
    join
    model[0][3] = 16'h1111;
    chk(lat == 4, "R9 first access unaffected", lat, 4);
    end_cycle();
    extra = 0;
    repeat (8) begin @(negedge clk); if (ack_drv) extra = 1; end
    chk(!extra, "R9 no acknowledge for busy strobe", extra, 0);
    do_access(0, 4, 0, 0, 4, "R9 busy strobe wrote nothing");
    do_access(0, 3, 0, 0, 4, "R9 original write intact");
  endtask

  task automatic t_cs_high();
    bit seen;
    @(negedge clk);
    cs_n = 1; as_n = 0; rw = 0; addr = mk_addr(1, 6); wdata = 16'h5555;
    @(negedge clk);
    as_n = 1; wdata = 16'h5555;
    seen = 0;
    repeat (8) begin @(negedge clk); if (ack_drv) seen = 1; end
    rw = 1;
    chk(!seen, "R10 no acknowledge for deselected strobe", seen, 0);
    do_access(1, 6, 0, 0, 4, "R10 deselected strobe wrote nothing");
  endtask

  task automatic t_cs_drop();
    int lat;
    start_cycle(2, 0, 0, 0);
    fork
      wait_ack(lat);
      begin @(negedge clk); cs_n = 1; end
    join
    chk(lat == 4 && ack_drv, "R4 sequencer still drives with cs high", lat, 4);
    chk(!ack_oe, "R4 pad disabled while cs high", ack_oe, 0);
    end_cycle();
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_shared();
    t_contend();
    t_busy();
    t_cs_high();
    t_cs_drop();
    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule